// File: doc/BRIEF.md
# FIFO-Fed Pulse-Width Modulator

This block generates one pulse-width modulated output. Software programs it through a small synchronous word-addressed register port. A period register sets the length of each PWM cycle. Duty values ("samples") are queued into a four-entry FIFO, and a compare stage turns the active sample into a high time. A prescaler divides one of three externally supplied clock-enable strobes before the period counter uses it.

At each rollover the block takes a new sample from the FIFO, once the current sample has served its programmed number of periods. If the FIFO has run dry, the block keeps the last sample and raises a flag. Software polls a status word for the FIFO fill level and for sticky event flags. A self-clearing soft reset returns the whole block to its idle state.

Top module: `fifo_pwm`

## Requirements
- R1: After reset every register reads 0 and `pwm_out` is low. The word addresses are 0 for control, 1 for status, 3 for sample and 4 for period (byte offsets 0x0, 0x4, 0xC and 0x10).
- R2: The FIFO holds up to 4 samples, and status bits 2:0 show how many are queued. A sample write while 4 are queued is discarded and sets status bit 6.
- R3: The status flags are sticky and are cleared by writing 1 to their bit. Bit 3 means a refill found the FIFO empty. Bit 4 means a period rolled over. Bit 5 means a prescaled tick arrived while the count equalled the active sample. Bit 6 means a sample write was lost.
- R4: A period lasts (period register + 2) prescaled ticks. In normal mode the output is high from the start of the period for as many ticks as the active sample value, capped at the period length.
- R5: A period register value of 0xFFFF gives the same 65536-tick period as 0xFFFE.
- R6: Control bits 15:4 hold the prescale divide ratio minus one, so the ratio ranges from 1 to 4096.
- R7: Control bits 17:16 select the tick strobe. 0 selects none, so the counter is frozen. 1 selects `tick_bus`, 2 selects `tick_fast` and 3 selects `tick_slow`.
- R8: Control bits 2:1 (values 0 to 3) make each sample serve for 1, 2, 4 or 8 consecutive periods.
- R9: Enabling the block loads the first queued sample. At a rollover that ends the sample's repeat run, the next entry is taken. If the FIFO is empty, the last sample is kept and status bit 3 is set.
- R10: Control bits 19:18 choose the output mode. 0 is normal, 1 is inverted, and 2 or 3 hold the output low.
- R11: Control bit 0 enables the counter. While it is 0, `pwm_out` is low in every mode, and the sample register reads 0. While it is 1, the sample register reads the active sample.
- R12: Writing control bit 3 clears the FIFO, counters, registers and flags. The bit reads back as 1 for SRST_CYCLES cycles, during which register writes are ignored, and then it reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_bus | input | 1 | Clock-enable strobe, source 1 |
| tick_fast | input | 1 | Clock-enable strobe, source 2 |
| tick_slow | input | 1 | Clock-enable strobe, source 3 |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pwm_out | output | 1 | Modulated output |

## Verification
The hardest situation to reach is the end of a repeat run with an empty FIFO. To get there, the FIFO must be filled and drained across several rollovers while the repeat counter is mid-run. The bench preloads a known sample list and then counts high cycles period by period, so every refill and the final hold show up as a distinct expected count. The 0xFFFF period equivalence needs a full 65536-tick period, and the bench checks the rollover flag on the cycle before that boundary and on the cycle of it.

// File: rtl/fifo_pwm_pkg.sv
// Shared constants and encodings for the FIFO-fed PWM.
// Assumes a 32-bit register port with word addresses.
package fifo_pwm_pkg;
    localparam int BUS_W   = 32;
    localparam int ADDR_W  = 3;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
    localparam logic [ADDR_W-1:0] A_SAMP = 3'd3;
    localparam logic [ADDR_W-1:0] A_PER  = 3'd4;

    // control field positions
    localparam int C_EN    = 0;
    localparam int C_REP   = 1;
    localparam int C_SRST  = 3;
    localparam int C_PRE   = 4;
    localparam int C_SRC   = 16;
    localparam int C_MODE  = 18;

    // status flag positions
    localparam int S_EMPTY = 3;
    localparam int S_ROLL  = 4;
    localparam int S_CMP   = 5;
    localparam int S_WERR  = 6;

    typedef enum logic [1:0] {
        OUT_NORMAL = 2'd0,
        OUT_INVERT = 2'd1,
        OUT_LOW_A  = 2'd2,
        OUT_LOW_B  = 2'd3
    } out_mode_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_BUS  = 2'd1,
        SRC_FAST = 2'd2,
        SRC_SLOW = 2'd3
    } tick_src_e;
endpackage

// File: rtl/fifo_pwm_fifo.sv
// Sample queue: a small circular buffer with a fill count.
// Assumes the caller never pushes when full or pops when empty.
module fifo_pwm_fifo #(
    parameter int W      = 16,
    parameter int DEPTH  = 4,
    parameter int FILL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic [W-1:0]      din,
    input  logic              pop,
    output logic [W-1:0]      dout,
    output logic [FILL_W-1:0] fill,
    output logic              full,
    output logic              empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // storage write
    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    // pointers and fill count
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp   <= '0;
            rp   <= '0;
            fill <= '0;
        end else begin
            if (push) wp <= nxt(wp);
            if (pop)  rp <= nxt(rp);
            fill <= fill + FILL_W'(push) - FILL_W'(pop);
        end
    end

    assign dout  = mem[rp];
    assign full  = (fill == FILL_W'(DEPTH));
    assign empty = (fill == '0);
endmodule

// File: rtl/fifo_pwm_tick.sv
// Strobe select and prescaler: emits one tick per PRE+1 selected strobes.
// Assumes the strobes are already synchronous to clk.
module fifo_pwm_tick #(
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [1:0]       src,
    input  logic             tick_bus,
    input  logic             tick_fast,
    input  logic             tick_slow,
    input  logic [PRE_W-1:0] pre,
    output logic             ptick
);
    import fifo_pwm_pkg::*;

    logic             strobe;
    logic [PRE_W-1:0] pcnt;
    logic             wrap;

    // pick the selected strobe
    always_comb begin
        case (tick_src_e'(src))
            SRC_BUS:  strobe = tick_bus;
            SRC_FAST: strobe = tick_fast;
            SRC_SLOW: strobe = tick_slow;
            default:  strobe = 1'b0;
        endcase
    end

    assign wrap  = (pcnt >= pre);
    assign ptick = strobe && wrap && !clr;

    // divide counter
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  pcnt <= '0;
        else if (strobe)    pcnt <= wrap ? '0 : pcnt + 1'b1;
    end
endmodule

// File: rtl/fifo_pwm_core.sv
// Period counter, repeat counter and active sample register.
// Raises a pop request at enable and at the end of each repeat run.
// Assumes period and repeat settings change only between runs.
module fifo_pwm_core #(
    parameter int W     = 16,
    parameter int REP_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             start,
    input  logic             ptick,
    input  logic [W-1:0]     period,
    input  logic [REP_W-1:0] rep_sel,
    input  logic [W-1:0]     head,
    input  logic             head_ok,
    output logic [W-1:0]     active,
    output logic             pop,
    output logic             ev_roll,
    output logic             ev_cmp,
    output logic             ev_starve,
    output logic             below
);
    localparam int RC_W = (1 << REP_W) - 1;

    logic [W-1:0]    cnt, last;
    logic [RC_W-1:0] rep_cnt, rep_end;
    logic            advance;

    // all-ones period behaves as all-ones minus one: last count is all ones
    assign last      = (&period) ? period : period + 1'b1;
    assign rep_end   = RC_W'((1 << rep_sel) - 1);
    assign ev_roll   = en && ptick && (cnt >= last);
    assign ev_cmp    = en && ptick && (cnt == active);
    assign advance   = ev_roll && (rep_cnt == rep_end);
    assign pop       = (start || advance) && head_ok;
    assign ev_starve = advance && !head_ok;
    assign below     = (cnt < active);

    // period and repeat counters
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !en || start) begin
            cnt     <= '0;
            rep_cnt <= '0;
        end else if (ev_roll) begin
            cnt     <= '0;
            rep_cnt <= advance ? '0 : rep_cnt + 1'b1;
        end else if (ptick) begin
            cnt     <= cnt + 1'b1;
        end
    end

    // active sample; kept when the queue is empty
    always_ff @(posedge clk) begin
        if (!rst_n || clr) active <= '0;
        else if (pop)      active <= head;
    end
endmodule

// File: rtl/fifo_pwm.sv
// FIFO-fed PWM top: register port, flags, soft reset and output stage.
// Assumes a single-cycle write strobe and combinational reads.
module fifo_pwm #(
    parameter int DATA_W      = 16,
    parameter int PRE_W       = 12,
    parameter int FIFO_DEPTH  = 4,
    parameter int SRST_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_bus,
    input  logic        tick_fast,
    input  logic        tick_slow,
    input  logic        bus_we,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        pwm_out
);
    import fifo_pwm_pkg::*;

    localparam int FILL_W = $clog2(FIFO_DEPTH + 1);
    localparam int SR_W   = $clog2(SRST_CYCLES + 1);

    logic              en;
    logic [1:0]        rep_sel, src, mode;
    logic [PRE_W-1:0]  pre;
    logic [DATA_W-1:0] period, active, head;
    logic [SR_W-1:0]   srst_cnt;
    logic              busy;
    logic              f_empty, f_roll, f_cmp, f_werr;
    logic [FILL_W-1:0] fill;
    logic              full, empty, push, pop, start, ptick, below;
    logic              ev_roll, ev_cmp, ev_starve;
    logic              wr_ctrl, wr_stat, wr_samp, wr_per;
    logic              unused_hi;

    assign unused_hi = ^bus_wdata[31:20];

    assign busy    = (srst_cnt != '0);
    assign wr_ctrl = bus_we && !busy && (bus_addr == A_CTRL);
    assign wr_stat = bus_we && !busy && (bus_addr == A_STAT);
    assign wr_samp = bus_we && !busy && (bus_addr == A_SAMP);
    assign wr_per  = bus_we && !busy && (bus_addr == A_PER);
    assign start   = wr_ctrl && bus_wdata[C_EN] && !bus_wdata[C_SRST] && !en;
    assign push    = wr_samp && !full;

    // soft reset sequencer
    always_ff @(posedge clk) begin
        if (!rst_n)                           srst_cnt <= '0;
        else if (wr_ctrl && bus_wdata[C_SRST]) srst_cnt <= SR_W'(SRST_CYCLES);
        else if (busy)                        srst_cnt <= srst_cnt - 1'b1;
    end

    // control and period registers
    always_ff @(posedge clk) begin
        if (!rst_n || busy) begin
            en <= 1'b0; rep_sel <= '0; pre <= '0; src <= '0; mode <= '0;
            period <= '0;
        end else begin
            if (wr_ctrl) begin
                en      <= bus_wdata[C_EN] && !bus_wdata[C_SRST];
                rep_sel <= bus_wdata[C_SRST] ? '0 : bus_wdata[C_REP +: 2];
                pre     <= bus_wdata[C_SRST] ? '0 : bus_wdata[C_PRE +: PRE_W];
                src     <= bus_wdata[C_SRST] ? '0 : bus_wdata[C_SRC +: 2];
                mode    <= bus_wdata[C_SRST] ? '0 : bus_wdata[C_MODE +: 2];
            end
            if (wr_per) period <= bus_wdata[DATA_W-1:0];
        end
    end

    // sticky flags, write one to clear
    always_ff @(posedge clk) begin
        if (!rst_n || busy) begin
            f_empty <= 1'b0; f_roll <= 1'b0; f_cmp <= 1'b0; f_werr <= 1'b0;
        end else begin
            f_empty <= (f_empty && !(wr_stat && bus_wdata[S_EMPTY])) || ev_starve;
            f_roll  <= (f_roll  && !(wr_stat && bus_wdata[S_ROLL]))  || ev_roll;
            f_cmp   <= (f_cmp   && !(wr_stat && bus_wdata[S_CMP]))   || ev_cmp;
            f_werr  <= (f_werr  && !(wr_stat && bus_wdata[S_WERR]))  || (wr_samp && full);
        end
    end

    fifo_pwm_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH), .FILL_W(FILL_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr(busy), .push(push),
        .din(bus_wdata[DATA_W-1:0]), .pop(pop), .dout(head),
        .fill(fill), .full(full), .empty(empty)
    );

    fifo_pwm_tick #(.PRE_W(PRE_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr(busy || !en || start), .src(src),
        .tick_bus(tick_bus), .tick_fast(tick_fast), .tick_slow(tick_slow),
        .pre(pre), .ptick(ptick)
    );

    fifo_pwm_core #(.W(DATA_W), .REP_W(2)) u_core (
        .clk(clk), .rst_n(rst_n), .clr(busy), .en(en), .start(start),
        .ptick(ptick), .period(period), .rep_sel(rep_sel), .head(head),
        .head_ok(!empty), .active(active), .pop(pop), .ev_roll(ev_roll),
        .ev_cmp(ev_cmp), .ev_starve(ev_starve), .below(below)
    );

    // output stage
    always_comb begin
        case (out_mode_e'(mode))
            OUT_NORMAL: pwm_out = en && below;
            OUT_INVERT: pwm_out = en && !below;
            default:    pwm_out = 1'b0;
        endcase
    end

    // register read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: begin
                bus_rdata[C_EN]          = en;
                bus_rdata[C_REP +: 2]    = rep_sel;
                bus_rdata[C_SRST]        = busy;
                bus_rdata[C_PRE +: PRE_W] = pre;
                bus_rdata[C_SRC +: 2]    = src;
                bus_rdata[C_MODE +: 2]   = mode;
            end
            A_STAT: begin
                bus_rdata[FILL_W-1:0] = fill;
                bus_rdata[S_EMPTY]    = f_empty;
                bus_rdata[S_ROLL]     = f_roll;
                bus_rdata[S_CMP]      = f_cmp;
                bus_rdata[S_WERR]     = f_werr;
            end
            A_SAMP:  bus_rdata[DATA_W-1:0] = en ? active : '0;
            A_PER:   bus_rdata[DATA_W-1:0] = period;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/fifo_pwm_chk.sv
// Property checker for fifo_pwm, attached with bind.
// Assumes it observes the top's internal enable, mode, busy and FIFO handshake.
module fifo_pwm_chk #(
    parameter int DEPTH  = 4,
    parameter int FILL_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic [1:0]        mode,
    input logic              busy,
    input logic              samp_wr,
    input logic              push,
    input logic              pop,
    input logic [FILL_W-1:0] fill,
    input logic              werr,
    input logic              pwm_out
);
    // R11
    dis_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !pwm_out);
    // R10
    mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode[1]) |-> !pwm_out);
    // R2
    fill_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FILL_W'(DEPTH));
    // R2
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_wr && !busy && fill == FILL_W'(DEPTH) && !pop) |=>
        (fill == FILL_W'(DEPTH) && werr));
    // R12
    srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (fill == '0 && !en));
    // R9
    pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !busy) |=> (fill == FILL_W'($past(fill) - 1'b1)));
endmodule

bind fifo_pwm fifo_pwm_chk #(.DEPTH(FIFO_DEPTH), .FILL_W(FILL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .busy(busy),
    .samp_wr(bus_we && bus_addr == 3'd3), .push(push), .pop(pop),
    .fill(fill), .werr(f_werr), .pwm_out(pwm_out)
);

// File: tb/fifo_pwm_tb.sv
// Scoreboard bench: driver queues expected high counts per period,
// monitor counts output highs per window and compares.
module fifo_pwm_tb;
    localparam logic [2:0] CT = 3'd0, ST = 3'd1, SA = 3'd3, PE = 3'd4;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        tick_bus = 1'b1, tick_fast = 1'b1, tick_slow = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwm_out;

    int total = 0, bad = 0, cycles = 0;
    int    exp_q[$];
    string tag_q[$];
    int    mon_len = 1, acc = 0, cyc = 0;
    bit    mon_on = 0;
    logic [31:0] rv;

    fifo_pwm u_dut (
        .clk(clk), .rst_n(rst_n), .tick_bus(tick_bus), .tick_fast(tick_fast),
        .tick_slow(tick_slow), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic expect_hi(input string tag, input int v);
        exp_q.push_back(v); tag_q.push_back(tag);
    endtask

    // write that starts monitoring at the first cycle it takes effect
    task automatic wr_mon(input logic [2:0] a, input logic [31:0] d, input int len);
        @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_we = 1'b0;
        acc = 0; cyc = 0; mon_len = len; mon_on = 1;
    endtask

    task automatic drain;
        while (mon_on) @(negedge clk);
    endtask

    // monitor: count high cycles per window, pop and compare
    always @(negedge clk) begin
        #2;
        if (mon_on) begin
            acc += int'(pwm_out);
            cyc++;
            if (cyc == mon_len) begin
                chk(tag_q.pop_front(), acc, exp_q.pop_front());
                acc = 0; cyc = 0;
                if (exp_q.size() == 0) mon_on = 0;
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 / R13 reset values at word addresses
        rd(CT, rv); chk("R1 ctrl", rv, 0);
        rd(ST, rv); chk("R1 status", rv, 0);
        rd(SA, rv); chk("R1 sample", rv, 0);
        rd(PE, rv); chk("R1 period", rv, 0);
        chk("R1 out", pwm_out, 0);

        // R2 fill and overflow
        wr(PE, 6);
        wr(SA, 2); wr(SA, 5); wr(SA, 9); wr(SA, 1);
        rd(ST, rv); chk("R2 fill4", rv, 4);
        wr(SA, 7);
        rd(ST, rv); chk("R2 werr", rv, 32'h44);
        // R3 write one to clear
        wr(ST, 32'h40);
        rd(ST, rv); chk("R3 w1c", rv, 4);

        // R4 R9 normal, 1x, fast strobe, ratio 1, P=8
        expect_hi("R4 p1", 2); expect_hi("R9 p2", 5); expect_hi("R4 cap", 8);
        expect_hi("R9 p4", 1); expect_hi("R9 hold", 1);
        wr_mon(CT, 32'h2_0001, 8);
        rd(ST, rv); chk("R9 pop at enable", rv, 3);
        drain();
        rd(ST, rv); chk("R3 R9 flags", rv, 32'h38);
        rd(SA, rv); chk("R11 sample live", rv, 1);

        // R11 disabled output and sample read
        wr(CT, 32'h2_0000);
        chk("R11 off low", pwm_out, 0);
        rd(SA, rv); chk("R11 sample zero", rv, 0);
        wr(CT, 32'h6_0000);
        chk("R11 inverted off low", pwm_out, 0);

        // R12 soft reset
        wr(SA, 3);
        wr(CT, 32'h8);
        rd(CT, rv); chk("R12 busy bit", rv, 8);
        wr(PE, 5);
        repeat (6) @(negedge clk);
        rd(CT, rv); chk("R12 ctrl clear", rv, 0);
        rd(ST, rv); chk("R12 status clear", rv, 0);
        rd(PE, rv); chk("R12 write ignored", rv, 0);

        // R8 R10 repeat 2x, inverted, P=4
        wr(PE, 2); wr(SA, 1); wr(SA, 3);
        expect_hi("R8 a1", 3); expect_hi("R8 a2", 3);
        expect_hi("R10 b1", 1); expect_hi("R8 b2", 1);
        expect_hi("R9 hold1", 1); expect_hi("R9 hold2", 1);
        wr_mon(CT, 32'h6_0003, 4);
        drain();

        // R6 prescale ratio 3, P=2
        wr(CT, 0); wr(PE, 0); wr(SA, 1);
        expect_hi("R6 d1", 3); expect_hi("R6 d2", 3); expect_hi("R6 d3", 3);
        wr_mon(CT, 32'h2_0021, 6);
        drain();

        // R7 slow strobe held low freezes the counter
        wr(CT, 0); wr(ST, 32'h78);
        wr(PE, 2); wr(SA, 1);
        expect_hi("R7 frozen", 12);
        wr_mon(CT, 32'h3_0001, 12);
        drain();
        rd(ST, rv); chk("R7 no rollover", rv, 0);
        // R7 bus strobe runs
        wr(CT, 0); wr(SA, 2);
        expect_hi("R7 bus1", 2); expect_hi("R7 bus2", 2);
        wr_mon(CT, 32'h1_0001, 4);
        drain();
        // R10 muted mode
        expect_hi("R10 mute1", 0); expect_hi("R10 mute2", 0);
        wr_mon(CT, 32'hA_0001, 4);
        drain();

        // R5 all-ones period equals 65536 ticks
        wr(CT, 0); wr(ST, 32'h78); wr(PE, 32'hFFFF); wr(SA, 0);
        wr(CT, 32'h2_0001);
        repeat (65535) @(negedge clk);
        rd(ST, rv); chk("R5 before edge", int'(rv[4]), 0);
        @(negedge clk);
        rd(ST, rv); chk("R5 at edge", int'(rv[4]), 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule